// File: doc/BRIEF.md
# Split Serial Access Buffer Controller

This block models the serial side of a dual-ported video memory. A row store holds whole rows. A serial buffer twice the size of a half holds one row image and is split into a lower half and an upper half. A full read command copies a whole row into the buffer, sets the serial port to output and places the serial pointer at a 9-bit start address. A serial clock enable then steps the pointer, and each step presents the word at the pointer.

Split read commands refill only the half that is not being streamed. They also leave a pending start offset for that half. When the pointer leaves the last word of a half, it continues in the other half at that pending offset, or at offset zero if none is pending. The half flag follows the crossing. A write command copies the buffer back into a row and turns the port to input, so that serial clocks fill the buffer from the data input.

All inputs are sampled on the rising edge of `clk_i`, and the serial clock is a one-cycle enable in that domain. A split command may arrive in any cycle relative to the serial clock.

Top module: `split_sam_ctrl`

## Requirements
- R1: A read command (`xfer_i`=1, `xfer_wr_i`=0, `split_i`=0) copies the whole addressed row into the buffer. After the edge, `saddr_o` equals all 9 bits of `tap_i` and `dir_out_o` is 1.
- R2: With `sclk_i`=1 and no command, `sdata_o` shows the buffer word at `saddr_o` in that cycle. If `saddr_o[7:0]` is not 255, the pointer then increments by one.
- R3: On a step at position 255 of a half, the pointer moves to the other half (bit 8 inverted) at that half's pending offset, and `half_o` (which equals `saddr_o[8]`; 1 means the upper half) toggles.
- R4: If no offset is pending for the next half, the crossing continues at offset 0, which is word 0 or word 256. A crossing uses up the pending offset, so a later crossing with no new split command falls back to 0.
- R5: A split read command (`split_i`=1) loads only the half that is not being streamed from the addressed row and records `tap_i[7:0]` as that half's pending offset. `tap_i[8]` is ignored, and the pointer and the streamed half are unchanged.
- R6: A split read command leaves `dir_out_o` unchanged, and a serial step in the same cycle proceeds normally.
- R7: A split read command is ignored unless a read command has occurred since reset or since the last write command. In that case `split_err_o` is 1 for exactly the following cycle, and no data or offset is taken.
- R8: A write command (`xfer_wr_i`=1) copies the buffer into the addressed row, loads `saddr_o` with `tap_i` and clears `dir_out_o`. With `dir_out_o`=0, each serial step writes `sdata_i` into the buffer at the pointer and advances it.
- R9: A read or write command in the same cycle as a serial step takes precedence. The pointer takes the tap, with no increment.
- R10: A split command in the same cycle as a step from position 255 supplies the offset that this crossing uses.
- R11: After reset, `saddr_o`=0, `half_o`=0, `dir_out_o`=0 and `split_err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_i | input | 1 | Command strobe |
| xfer_wr_i | input | 1 | Command is a write (buffer to row) |
| split_i | input | 1 | Command is a half-only split read |
| row_i | input | ROW_W | Row address |
| tap_i | input | POS_W+1 | Start address; bit 8 is ignored on split commands |
| sclk_i | input | 1 | Serial clock enable, one step per cycle |
| sdata_i | input | DATA_W | Serial input word |
| sdata_o | output | DATA_W | Buffer word at the pointer |
| saddr_o | output | POS_W+1 | Serial pointer |
| half_o | output | 1 | 1 while the upper half is streamed |
| dir_out_o | output | 1 | 1 when the port is in output mode |
| split_err_o | output | 1 | Pulse for an ignored split command |

## Verification
The bench streams across both half boundaries with a pending offset, with no offset, and with an offset already used up. A design that keeps used offsets would restart at a stale position instead of word 0 or 256. A split command issued on the very step that crosses the boundary catches a design that drops the offset or leaves it pending for the wrong half. Another test issues a full command together with a serial step, and a design that lets the step win lands one word past the tap. The bench also sends split commands before any read command and after a write command. Honouring them would corrupt buffer data and miss the error pulse. Honouring tap bit 8 would send the data to the streamed half.

// File: rtl/split_sam_pkg.sv
`timescale 1ns/1ps
package split_sam_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE,
    CMD_READ,
    CMD_SPLIT,
    CMD_WRITE
  } sam_cmd_e;
endpackage

// File: rtl/row_array.sv
`timescale 1ns/1ps
module row_array #(
  parameter int DATA_W = 4,
  parameter int POS_W = 8,
  parameter int ROWS = 4,
  localparam int ROW_W = $clog2(ROWS),
  localparam int ROW_BITS = (2 ** (POS_W + 1)) * DATA_W
) (
  input  logic                clk_i,
  input  logic                we_i,
  input  logic [ROW_W-1:0]    addr_i,
  input  logic [ROW_BITS-1:0] wdata_i,
  output logic [ROW_BITS-1:0] rdata_o
);
  logic [ROW_BITS-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/sam_buffer.sv
`timescale 1ns/1ps
module sam_buffer #(
  parameter int DATA_W = 4,
  parameter int POS_W = 8,
  localparam int HALF_BITS = (2 ** POS_W) * DATA_W,
  localparam int ROW_BITS = 2 * HALF_BITS
) (
  input  logic                clk_i,
  input  logic                full_ld_i,
  input  logic                half_ld_i,
  input  logic                half_sel_i,
  input  logic [ROW_BITS-1:0] row_i,
  input  logic                wr_i,
  input  logic [POS_W:0]      ptr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [ROW_BITS-1:0] buf_o,
  output logic [DATA_W-1:0]   rdata_o
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_BITS-1:0] q;
    always_ff @(posedge clk_i) begin
      if (full_ld_i) begin
        q <= row_i[h*HALF_BITS +: HALF_BITS];
      end else begin
        if (half_ld_i && (half_sel_i == 1'(h))) q <= row_i[h*HALF_BITS +: HALF_BITS];
        if (wr_i && (ptr_i[POS_W] == 1'(h))) q[ptr_i[POS_W-1:0]*DATA_W +: DATA_W] <= wdata_i;
      end
    end
  end

  assign buf_o   = {g_half[1].q, g_half[0].q};
  assign rdata_o = buf_o[ptr_i*DATA_W +: DATA_W];
endmodule

// File: rtl/sam_ptr_ctrl.sv
`timescale 1ns/1ps
module sam_ptr_ctrl
  import split_sam_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  sam_cmd_e     cmd_i,
  input  logic [POS_W:0] tap_i,
  input  logic         step_i,
  output logic [POS_W:0] ptr_o,
  output logic         dir_out_o,
  output logic         split_ok_o,
  output logic         idle_half_o,
  output logic         ser_wr_o,
  output logic         err_o
);
  logic [POS_W:0]   ptr_q;
  logic             dir_q, seen_q, err_q;
  logic [1:0]       pv_q;
  logic [POS_W-1:0] pt_q [2];
  logic             nxt_h, at_end, split_ok;
  logic [POS_W-1:0] jump_pos;

  assign nxt_h    = ~ptr_q[POS_W];
  assign at_end   = &ptr_q[POS_W-1:0];
  assign split_ok = (cmd_i == CMD_SPLIT) && seen_q;

  // a split arriving on the crossing step forwards its offset
  always_comb begin
    if (split_ok)         jump_pos = tap_i[POS_W-1:0];
    else if (pv_q[nxt_h]) jump_pos = pt_q[nxt_h];
    else                  jump_pos = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      dir_q   <= 1'b0;
      seen_q  <= 1'b0;
      err_q   <= 1'b0;
      pv_q    <= '0;
      pt_q[0] <= '0;
      pt_q[1] <= '0;
    end else begin
      err_q <= (cmd_i == CMD_SPLIT) && !seen_q;
      unique case (cmd_i)
        CMD_READ: begin
          ptr_q  <= tap_i;
          dir_q  <= 1'b1;
          seen_q <= 1'b1;
          pv_q   <= '0;
        end
        CMD_WRITE: begin
          ptr_q  <= tap_i;
          dir_q  <= 1'b0;
          seen_q <= 1'b0;
          pv_q   <= '0;
        end
        default: begin
          if (split_ok) begin
            pv_q[nxt_h] <= 1'b1;
            pt_q[nxt_h] <= tap_i[POS_W-1:0];
          end
          if (step_i) begin
            if (at_end) begin
              ptr_q       <= {nxt_h, jump_pos};
              pv_q[nxt_h] <= 1'b0;
            end else begin
              ptr_q <= ptr_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign ptr_o       = ptr_q;
  assign dir_out_o   = dir_q;
  assign split_ok_o  = split_ok;
  assign idle_half_o = nxt_h;
  assign ser_wr_o    = step_i && !dir_q && ((cmd_i == CMD_IDLE) || (cmd_i == CMD_SPLIT));
  assign err_o       = err_q;
endmodule

// File: rtl/split_sam_ctrl.sv
`timescale 1ns/1ps
module split_sam_ctrl
  import split_sam_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int POS_W = 8,
  parameter int ROWS = 4,
  localparam int ADDR_W = POS_W + 1,
  localparam int ROW_W = $clog2(ROWS),
  localparam int ROW_BITS = (2 ** ADDR_W) * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  logic              xfer_wr_i,
  input  logic              split_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [ADDR_W-1:0] tap_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sdata_i,
  output logic [DATA_W-1:0] sdata_o,
  output logic [ADDR_W-1:0] saddr_o,
  output logic              half_o,
  output logic              dir_out_o,
  output logic              split_err_o
);
  sam_cmd_e            cmd;
  logic [ADDR_W-1:0]   ptr;
  logic                split_ok, idle_half, ser_wr;
  logic [ROW_BITS-1:0] row_data, buf_data;

  always_comb begin
    if (!xfer_i)        cmd = CMD_IDLE;
    else if (xfer_wr_i) cmd = CMD_WRITE;
    else if (split_i)   cmd = CMD_SPLIT;
    else                cmd = CMD_READ;
  end

  sam_ptr_ctrl #(.POS_W(POS_W)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .tap_i       (tap_i),
    .step_i      (sclk_i),
    .ptr_o       (ptr),
    .dir_out_o   (dir_out_o),
    .split_ok_o  (split_ok),
    .idle_half_o (idle_half),
    .ser_wr_o    (ser_wr),
    .err_o       (split_err_o)
  );

  row_array #(.DATA_W(DATA_W), .POS_W(POS_W), .ROWS(ROWS)) u_rows (
    .clk_i   (clk_i),
    .we_i    (cmd == CMD_WRITE),
    .addr_i  (row_i),
    .wdata_i (buf_data),
    .rdata_o (row_data)
  );

  sam_buffer #(.DATA_W(DATA_W), .POS_W(POS_W)) u_buf (
    .clk_i      (clk_i),
    .full_ld_i  (cmd == CMD_READ),
    .half_ld_i  (split_ok),
    .half_sel_i (idle_half),
    .row_i      (row_data),
    .wr_i       (ser_wr),
    .ptr_i      (ptr),
    .wdata_i    (sdata_i),
    .buf_o      (buf_data),
    .rdata_o    (sdata_o)
  );

  assign saddr_o = ptr;
  assign half_o  = ptr[POS_W];
endmodule

// File: rtl/split_sam_chk.sv
`timescale 1ns/1ps
module split_sam_chk #(
  parameter int POS_W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           xfer_i,
  input logic           xfer_wr_i,
  input logic           split_i,
  input logic [POS_W:0] tap_i,
  input logic           sclk_i,
  input logic [POS_W:0] saddr_o,
  input logic           half_o,
  input logic           dir_out_o,
  input logic           split_err_o
);
  logic seen_q, rd_cmd, wr_cmd, sp_cmd;
  assign rd_cmd = xfer_i && !xfer_wr_i && !split_i;
  assign wr_cmd = xfer_i && xfer_wr_i;
  assign sp_cmd = xfer_i && !xfer_wr_i && split_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= 1'b0;
    else if (rd_cmd) seen_q <= 1'b1;
    else if (wr_cmd) seen_q <= 1'b0;
  end

  // R1 R9
  rd_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd |=> dir_out_o && (saddr_o == $past(tap_i)));
  // R8
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd |=> !dir_out_o && (saddr_o == $past(tap_i)));
  // R2
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && !xfer_i && !(&saddr_o[POS_W-1:0])) |=> saddr_o == $past(saddr_o) + 1'b1);
  // R3
  cross_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && !rd_cmd && !wr_cmd && (&saddr_o[POS_W-1:0])) |=> half_o != $past(half_o));
  // R6
  split_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_cmd |=> $stable(dir_out_o));
  // R7
  split_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_cmd && !seen_q) |=> split_err_o);
  // R7
  split_err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sp_cmd && !seen_q) |=> !split_err_o);
endmodule

bind split_sam_ctrl split_sam_chk #(.POS_W(POS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xfer_i      (xfer_i),
  .xfer_wr_i   (xfer_wr_i),
  .split_i     (split_i),
  .tap_i       (tap_i),
  .sclk_i      (sclk_i),
  .saddr_o     (saddr_o),
  .half_o      (half_o),
  .dir_out_o   (dir_out_o),
  .split_err_o (split_err_o)
);

// File: tb/split_sam_ctrl_tb.sv
`timescale 1ns/1ps
module split_sam_ctrl_tb;
  localparam int DW = 4;
  localparam int PW = 8;
  localparam int ROWS = 4;
  localparam int AW = PW + 1;
  localparam int WORDS = 2 ** AW;
  localparam int RW = $clog2(ROWS);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, xfer_i, xfer_wr_i, split_i, sclk_i;
  logic [RW-1:0] row_i;
  logic [AW-1:0] tap_i, saddr_o;
  logic [DW-1:0] sdata_i, sdata_o;
  logic half_o, dir_out_o, split_err_o;

  split_sam_ctrl #(.DATA_W(DW), .POS_W(PW), .ROWS(ROWS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .xfer_i(xfer_i), .xfer_wr_i(xfer_wr_i),
    .split_i(split_i), .row_i(row_i), .tap_i(tap_i), .sclk_i(sclk_i),
    .sdata_i(sdata_i), .sdata_o(sdata_o), .saddr_o(saddr_o), .half_o(half_o),
    .dir_out_o(dir_out_o), .split_err_o(split_err_o)
  );

  typedef struct {
    string         req;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } exp_t;
  exp_t q[$];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state derived from the requirements
  logic [DW-1:0] mdl_sam [WORDS];
  logic [DW-1:0] mdl_row [ROWS][WORDS];
  logic [AW-1:0] mdl_ptr;
  logic          mdl_dir, mdl_seen, mdl_err;
  logic [1:0]    mdl_pv;
  logic [PW-1:0] mdl_pt [2];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic end_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [DW-1:0] pat(input int r, input int i);
    return DW'((i + (i >> 4) + 5 * r + 9 * (i >> 8)) & 15);
  endfunction

  // monitor: pops one expected item per observed output step
  always @(negedge clk) begin
    #1;
    if (rst_ni && sclk_i && dir_out_o) begin
      if (q.size() == 0) begin
        check("R2 unexpected step", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.req, " addr"}, 32'(saddr_o), 32'(e.addr));
        check({e.req, " data"}, 32'(sdata_o), 32'(e.data));
        check({e.req, " half"}, 32'(half_o), 32'(e.addr[AW-1]));
      end
    end
  end

  task automatic cyc(input logic x, input logic w, input logic s, input int r,
                     input logic [AW-1:0] t, input logic sc, input logic [DW-1:0] sd,
                     input string req);
    logic nh, fwd;
    @(negedge clk);
    xfer_i = x; xfer_wr_i = w; split_i = s; row_i = RW'(r); tap_i = t;
    sclk_i = sc; sdata_i = sd;
    if (sc && mdl_dir) q.push_back('{req, mdl_ptr, mdl_sam[mdl_ptr]});
    mdl_err = x && !w && s && !mdl_seen;
    if (x && !w && !s) begin
      for (int i = 0; i < WORDS; i++) mdl_sam[i] = mdl_row[r][i];
      mdl_ptr = t; mdl_dir = 1'b1; mdl_seen = 1'b1; mdl_pv = '0;
    end else if (x && w) begin
      for (int i = 0; i < WORDS; i++) mdl_row[r][i] = mdl_sam[i];
      mdl_ptr = t; mdl_dir = 1'b0; mdl_seen = 1'b0; mdl_pv = '0;
    end else begin
      fwd = 1'b0;
      nh = ~mdl_ptr[AW-1];
      if (x && s && mdl_seen) begin
        for (int i = 0; i < WORDS / 2; i++)
          mdl_sam[int'(nh) * (WORDS / 2) + i] = mdl_row[r][int'(nh) * (WORDS / 2) + i];
        mdl_pv[nh] = 1'b1; mdl_pt[nh] = t[PW-1:0]; fwd = 1'b1;
      end
      if (sc) begin
        if (!mdl_dir) mdl_sam[mdl_ptr] = sd;
        if (&mdl_ptr[PW-1:0]) begin
          mdl_ptr = {nh, fwd ? t[PW-1:0] : (mdl_pv[nh] ? mdl_pt[nh] : PW'(0))};
          mdl_pv[nh] = 1'b0;
        end else begin
          mdl_ptr = mdl_ptr + 1'b1;
        end
      end
    end
    @(posedge clk);
    #1;
    xfer_i = 1'b0; xfer_wr_i = 1'b0; split_i = 1'b0; sclk_i = 1'b0;
  endtask

  task automatic stream(input int n, input string req);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, '0, 1, '0, req);
  endtask

  initial begin
    #(200000 * 5);
    check("watchdog expired", 1, 0);
    end_run();
  end

  initial begin
    rst_ni = 1'b0; xfer_i = 0; xfer_wr_i = 0; split_i = 0; sclk_i = 0;
    row_i = '0; tap_i = '0; sdata_i = '0;
    mdl_ptr = '0; mdl_dir = 0; mdl_seen = 0; mdl_err = 0; mdl_pv = '0;
    mdl_pt[0] = '0; mdl_pt[1] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R11
    check("R11 saddr", 32'(saddr_o), 0);
    check("R11 half", 32'(half_o), 0);
    check("R11 dir", 32'(dir_out_o), 0);
    check("R11 err", 32'(split_err_o), 0);

    // R7: split before any read is ignored and flagged
    cyc(1, 0, 1, 1, 9'h033, 0, '0, "R7");
    check("R7 err pulse", 32'(split_err_o), 1);
    check("R7 dir", 32'(dir_out_o), 0);
    check("R7 saddr", 32'(saddr_o), 0);
    cyc(0, 0, 0, 0, '0, 0, '0, "R7");
    check("R7 err one cycle", 32'(split_err_o), 0);

    // R8: fill each row through serial input and a write command
    for (int r = 0; r < ROWS; r++) begin
      for (int i = 0; i < WORDS; i++) cyc(0, 0, 0, 0, '0, 1, pat(r, int'(mdl_ptr)), "R8");
      cyc(1, 1, 0, r, '0, 0, '0, "R8");
      check("R8 dir", 32'(dir_out_o), 0);
    end

    // R1
    cyc(1, 0, 0, 0, 9'h0F0, 0, '0, "R1");
    check("R1 dir", 32'(dir_out_o), 1);
    check("R1 saddr", 32'(saddr_o), 32'h0F0);
    // R5: upper half loaded although tap bit 8 is 0
    cyc(1, 0, 1, 1, 9'h005, 0, '0, "R5");
    check("R6 dir after split", 32'(dir_out_o), 1);
    check("R5 saddr unchanged", 32'(saddr_o), 32'h0F0);
    stream(16, "R2");
    check("R3 crossing addr", 32'(saddr_o), 32'h105);
    check("R3 half", 32'(half_o), 1);
    stream(5, "R5");
    // R6: split of lower half with tap bit 8 set, concurrent with a step
    cyc(1, 0, 1, 2, 9'h110, 1, '0, "R6");
    check("R6 dir", 32'(dir_out_o), 1);
    check("R6 step taken", 32'(saddr_o), 32'h10B);
    stream(WORDS - int'(mdl_ptr), "R3");
    check("R3 wrap addr", 32'(saddr_o), 32'h010);
    // R4: no pending tap for upper, previous one consumed
    stream(240, "R4");
    check("R4 fallback addr", 32'(saddr_o), 32'h100);
    stream(255, "R4");
    check("R4 end of upper", 32'(saddr_o), 32'h1FF);
    // R10
    cyc(1, 0, 1, 3, 9'h007, 1, '0, "R10");
    check("R10 forwarded tap", 32'(saddr_o), 32'h007);
    stream(4, "R10");
    // R9
    cyc(1, 0, 0, 2, 9'h1AA, 1, '0, "R9");
    check("R9 command wins", 32'(saddr_o), 32'h1AA);
    stream(3, "R9");
    // R8: write command, serial input, copy back
    cyc(1, 1, 0, 3, 9'h100, 0, '0, "R8");
    check("R8 dir input", 32'(dir_out_o), 0);
    check("R8 saddr", 32'(saddr_o), 32'h100);
    cyc(0, 0, 0, 0, '0, 1, 4'hA, "R8");
    cyc(0, 0, 0, 0, '0, 1, 4'hB, "R8");
    check("R8 advance", 32'(saddr_o), 32'h102);
    // R7: split after a write command is ignored
    cyc(1, 0, 1, 1, 9'h020, 0, '0, "R7");
    check("R7 err after write", 32'(split_err_o), 1);
    check("R7 dir after write", 32'(dir_out_o), 0);
    cyc(1, 1, 0, 0, 9'h000, 0, '0, "R8");
    cyc(1, 0, 0, 0, 9'h100, 0, '0, "R8");
    stream(4, "R8");
    cyc(1, 0, 0, 3, 9'h0FE, 0, '0, "R8");
    stream(4, "R8");
    repeat (4) @(negedge clk);
    check("R2 queue drained", 32'(q.size()), 0);
    end_run();
  end
endmodule